// File: doc/BRIEF.md
# Auto-Reload Up/Down Timer Counter

An 8-bit timer counter with a small register interface. A clock-select field picks the count source. The source is either one of seven prescaled clock-enable strobes, which come from a prescaler outside the block, or edges on an external event pin. The external event pin passes through a two-flop synchroniser and an edge detector before it reaches the counter.

In interval mode the counter wraps freely at its limits. In auto-reload mode every overflow or underflow reloads the counter from a load register, which gives a programmable period of 1 to 256 count events. The count direction comes from a software bit, or, when hardware direction is enabled, from a synchronised up/down pin.

Writing the load register also copies the value into the counter at once, in both modes. Every overflow or underflow sets a sticky flag. The flag drives the interrupt output when the interrupt enable is set.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset the counter, the load register, the control register and the flag are all zero, and `irq` is low.
- R2: A write to address 1 (load) stores the value and copies it into the counter on the same edge, in both modes. Reading address 1 returns the load value, and reading address 2 returns the live count.
- R3: In interval mode (control bit 7 = 0), an up count from 0xFF gives 0x00 and a down count from 0x00 gives 0xFF. Each of these wraps is an overflow/underflow event.
- R4: In auto-reload mode (control bit 7 = 1), an overflow or underflow loads the counter from the load register. The period is 256-L count events counting up and L+1 counting down, where L is the load value.
- R5: Control bits 2:0 select the count source. Values 0 to 6 select `presc_tick[sel]`, and a strobe on any other source has no effect on the count.
- R6: Clock select 7 counts edges of `evt_pin`, through a two-flop synchroniser and an edge detector. Control bit 4 = 0 selects rising edges and 1 selects falling edges. Each edge gives exactly one count.
- R7: With control bit 6 = 1, the synchronised `ud_pin` sets the direction: low counts up, high counts down. With bit 6 = 0, control bit 5 sets the direction (0 up, 1 down).
- R8: Each overflow or underflow sets the flag (bit 0 of address 3). The flag stays set until a write to address 3 with bit 0 = 1 clears it. A write with bit 0 = 0 leaves it set, and a new event in the same cycle as a clear keeps it set.
- R9: `irq` is high exactly when the flag is set and control bit 3 (interrupt enable) is 1.
- R10: If a load write and a count event fall in the same cycle, the counter takes the written value and that count is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 load, 2 count, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| presc_tick | input | 7 | Prescaled clock-enable strobes, one per internal source |
| evt_pin | input | 1 | External event input, asynchronous |
| ud_pin | input | 1 | External direction input, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the auto-reload period over a spread of load values, including 0x00, 0xFE and 0xFF, in both directions. It checks that the flag stays clear for one count less than the period and then rises with the counter back at the load value. A design that is off by one at either limit, or that loads the wrong value, fails this sweep.

Each clock-select value is strobed against all the other sources. A wrong index into the source set therefore shows up as a stray or a missing count.

The bench also checks that a load write in the same cycle as a count leaves the counter at the written value, and that a write of 0 to the status register does not clear the flag. It checks that the pin direction overrides the software bit, and that each external edge in the selected polarity counts exactly once.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  // register addresses
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_LOAD = 2'd1;
  localparam logic [1:0] ADR_CNT  = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;
  // control register bit positions
  localparam int B_RELOAD = 7;
  localparam int B_HWDIR  = 6;
  localparam int B_SWDOWN = 5;
  localparam int B_FALL   = 4;
  localparam int B_IEN    = 3;
endpackage

// File: rtl/tmr_sync2.sv
module tmr_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic falling,
  output logic pulse
);
  logic lvl, lvl_prev;

  tmr_sync2 #(.W(1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_async), .q_sync(lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end

  assign pulse = falling ? (lvl_prev & ~lvl) : (lvl & ~lvl_prev);

  // R6: each detected edge gives a single-cycle count enable
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse && $stable(falling) |=> !pulse);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         tick,
  input  logic         down,
  input  logic         reload_mode,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] CMAX = '1;

  function automatic logic at_limit(input logic [W-1:0] cur, input logic dn);
    return dn ? (cur == '0) : (cur == CMAX);
  endfunction

  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur, input logic dn,
                                            input logic rl, input logic [W-1:0] rv);
    logic [W-1:0] r;
    if (at_limit(cur, dn)) r = rl ? rv : (dn ? CMAX : '0);
    else                   r = dn ? cur - 1'b1 : cur + 1'b1;
    return r;
  endfunction

  assign wrap = tick && !ld_en && at_limit(cnt, down);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (ld_en) cnt <= ld_val;
    else if (tick)  cnt <= next_val(cnt, down, reload_mode, reload_val);
  end

  // R2 / R10: a load write lands in the counter and wins over a count
  a_r2_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> cnt == $past(ld_val));
  // R3: interval mode wraps to the opposite limit
  a_r3_interval_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !reload_mode |=> cnt == ($past(down) ? CMAX : '0));
  // R4: auto-reload takes the load value on a wrap
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && reload_mode |=> cnt == $past(reload_val));
  // R5: without a count event or load the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ld_en |=> $stable(cnt));
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [1:0]            bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  output logic [CNT_W-1:0]      bus_rdata,
  input  logic [2**SEL_W-2:0]   presc_tick,
  input  logic                  evt_pin,
  input  logic                  ud_pin,
  output logic                  irq
);
  localparam int NSRC = 2**SEL_W;

  logic [CNT_W-1:0] ctrl_q, load_q, cnt;
  logic             flag_q, evt_pulse, ud_s, tick, down, wrap;
  logic             wr_ctrl, wr_load, wr_stat;
  logic [SEL_W-1:0] sel;
  logic [NSRC-1:0]  src_vec;

  assign wr_ctrl = bus_wr && bus_addr == ADR_CTRL;
  assign wr_load = bus_wr && bus_addr == ADR_LOAD;
  assign wr_stat = bus_wr && bus_addr == ADR_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_load) load_q <= bus_wdata;
      if (wrap)                      flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  tmr_edge_det u_evt (
    .clk(clk), .rst_n(rst_n), .pin_async(evt_pin),
    .falling(ctrl_q[B_FALL]), .pulse(evt_pulse)
  );

  tmr_sync2 #(.W(1)) u_ud (
    .clk(clk), .rst_n(rst_n), .d_async(ud_pin), .q_sync(ud_s)
  );

  assign sel     = ctrl_q[SEL_W-1:0];
  assign src_vec = {evt_pulse, presc_tick};
  assign tick    = src_vec[sel];
  assign down    = ctrl_q[B_HWDIR] ? ud_s : ctrl_q[B_SWDOWN];

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .ld_en(wr_load), .ld_val(bus_wdata),
    .tick(tick), .down(down),
    .reload_mode(ctrl_q[B_RELOAD]), .reload_val(load_q),
    .cnt(cnt), .wrap(wrap)
  );

  always_comb begin
    case (bus_addr)
      ADR_CTRL: bus_rdata = ctrl_q;
      ADR_LOAD: bus_rdata = load_q;
      ADR_CNT:  bus_rdata = cnt;
      default:  bus_rdata = {{(CNT_W-1){1'b0}}, flag_q};
    endcase
  end

  assign irq = flag_q & ctrl_q[B_IEN];

  // R8: a wrap always leaves the flag set
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);
  // R8: the flag is sticky until a write-one clear
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !(wr_stat && bus_wdata[0]) |=> flag_q);
  // R9: the interrupt never rises without the flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
endmodule

// File: tb/sim_updn_reload_timer.sv
module sim_updn_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [6:0] presc_tick = 7'd0;
  logic       evt_pin = 1'b0;
  logic       ud_pin = 1'b0;
  logic       irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  updn_reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .presc_tick(presc_tick),
    .evt_pin(evt_pin), .ud_pin(ud_pin), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata); bus_addr = 2'd2;
  endtask

  task automatic ticks(input int src, input int n);
    if (n > 0) begin
      presc_tick[src] = 1'b1;
      repeat (n) @(negedge clk);
      presc_tick[src] = 1'b0;
    end
  endtask

  task automatic evt_edge(input logic lvl);
    evt_pin = lvl;
    repeat (4) @(negedge clk);
  endtask

  int v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd2, v); chk("R1 count", v, 0);
    rd(2'd3, v); chk("R1 flag", v, 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", int'(irq), 0);

    // R2 load copies into counter (interval mode)
    wr(2'd1, 8'hFC);
    rd(2'd2, v); chk("R2 count after load", v, 8'hFC);
    rd(2'd1, v); chk("R2 load readback", v, 8'hFC);

    // R3 interval up wrap
    ticks(0, 3);
    rd(2'd2, v); chk("R3 at FF", v, 8'hFF);
    rd(2'd3, v); chk("R3 no flag before wrap", v, 0);
    ticks(0, 1);
    rd(2'd2, v); chk("R3 FF->00", v, 0);
    rd(2'd3, v); chk("R8 flag set on overflow", v, 1);
    chk("R9 irq off when disabled", int'(irq), 0);
    wr(2'd0, 8'h08);
    chk("R9 irq on when enabled", int'(irq), 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R8 write 0 keeps flag", v, 1);
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk("R8 write 1 clears flag", v, 0);
    chk("R9 irq drops with flag", int'(irq), 0);

    // R3 interval down wrap
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h01);
    ticks(0, 2);
    rd(2'd2, v); chk("R3 00->FF down", v, 8'hFF);
    rd(2'd3, v); chk("R3 underflow flag", v, 1);
    wr(2'd3, 8'h01);

    // R2 load copy in auto-reload mode
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h33);
    rd(2'd2, v); chk("R2 load copy reload mode", v, 8'h33);

    // R10 load write collides with a tick
    presc_tick[0] = 1'b1;
    wr(2'd1, 8'h40);
    presc_tick[0] = 1'b0;
    rd(2'd2, v); chk("R10 write wins over count", v, 8'h40);

    // R4 auto-reload period sweep, both directions
    for (int dir = 0; dir < 2; dir++) begin
      wr(2'd0, dir ? 8'hA0 : 8'h80);
      for (int k = 0; k < 18; k++) begin
        int ld, per, exp_cnt;
        ld = (k == 16) ? 254 : (k == 17) ? 1 : k * 17;
        per = dir ? ld + 1 : 256 - ld;
        wr(2'd1, 8'(ld));
        wr(2'd3, 8'h01);
        ticks(0, per - 1);
        exp_cnt = dir ? 0 : 255;
        rd(2'd2, v); chk("R4 count before reload", v, exp_cnt);
        rd(2'd3, v); chk("R4 no early flag", v, 0);
        ticks(0, 1);
        rd(2'd2, v); chk("R4 reloaded value", v, ld);
        rd(2'd3, v); chk("R4 flag at period end", v, 1);
      end
    end
    wr(2'd3, 8'h01);

    // R5 source select sweep
    for (int s = 0; s < 7; s++) begin
      wr(2'd0, 8'(s));
      wr(2'd1, 8'h10);
      presc_tick = ~(7'd1 << s);
      @(negedge clk);
      presc_tick = 7'd0;
      rd(2'd2, v); chk("R5 other sources ignored", v, 8'h10);
      ticks(s, 2);
      rd(2'd2, v); chk("R5 selected source counts", v, 8'h12);
    end

    // R6 external events, rising then falling
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h00);
    for (int i = 0; i < 3; i++) begin
      evt_edge(1'b1); evt_edge(1'b0);
    end
    rd(2'd2, v); chk("R6 rising edges counted once", v, 3);
    presc_tick = 7'h7F;
    @(negedge clk);
    presc_tick = 7'd0;
    rd(2'd2, v); chk("R5 prescaler ignored on select 7", v, 3);
    wr(2'd0, 8'h17);
    wr(2'd1, 8'h00);
    evt_edge(1'b1);
    rd(2'd2, v); chk("R6 rising ignored in falling mode", v, 0);
    evt_edge(1'b0);
    evt_edge(1'b1); evt_edge(1'b0);
    rd(2'd2, v); chk("R6 falling edges counted", v, 2);

    // R7 direction from the pin vs software
    wr(2'd0, 8'h60);
    wr(2'd1, 8'h50);
    ud_pin = 1'b0;
    repeat (3) @(negedge clk);
    ticks(0, 4);
    rd(2'd2, v); chk("R7 pin low counts up", v, 8'h54);
    ud_pin = 1'b1;
    repeat (3) @(negedge clk);
    ticks(0, 6);
    rd(2'd2, v); chk("R7 pin high counts down", v, 8'h4E);
    wr(2'd0, 8'h00);
    ticks(0, 2);
    rd(2'd2, v); chk("R7 software up ignores pin", v, 8'h50);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule